// File: doc/BRIEF.md
# Serial Audio Link Input Deframer

This block takes the serial stream that a codec sends to its controller over a five-wire audio link and breaks each frame apart into a 16-bit tag slot and twelve 20-bit data slots. It runs entirely on the falling edge of the link's bit clock. The codec launches bits on rising edges. A low-to-high transition of the frame sync input marks the start of a frame. From that point the block counts bit positions, shifts in every slot most significant bit first, and holds the finished slots in staging registers.

When the last bit of the final data slot has been captured, the codec-ready flag, the twelve per-slot valid tags and all twelve slot words update together, and a one-cycle frame-done strobe is raised. Downstream logic then has a full frame period to consume a coherent snapshot. At the nominal 12.288 MHz bit clock, a frame is 256 bit clocks, which gives a 48 kHz frame rate. A sync rise that arrives before a frame is complete discards the partial frame and starts a new count.

Top module: `slink_rx_deframer`

## Requirements
- R1: While rst_ni is low, codec_ready_o, slot_valid_o, slot_data_o and frame_done_o are all zero.
- R2: sync_i is sampled on falling edges of bit_clk_i, and a frame starts on a falling edge where sync_i is 1 and was 0 at the previous falling edge. Frame bit 0 is captured on the next falling edge, and bits 1 to 255 are captured on the falling edges that follow.
- R3: Each slot is received most significant bit first: the first bit of a slot lands in the top bit of that slot's word.
- R4: codec_ready_o takes the value of frame bit 0, which is tag-slot bit 15.
- R5: slot_valid_o[k-1] takes frame bit k, which is tag-slot bit 15-k, for data slot k = 1..12. Tag-slot bits 2 to 0 have no effect on any output.
- R6: slot_data_o[(k-1)*20 +: 20] holds data slot k exactly as received, zero bits included, with no masking. Slot k occupies frame bits 16+20*(k-1) to 35+20*(k-1).
- R7: frame_done_o is 1 for exactly one bit clock, starting at the falling edge that captures frame bit 255. codec_ready_o, slot_valid_o and slot_data_o change only on that edge.
- R8: A sync rise detected while frame bits 0 to 254 are still being collected abandons the partial frame. No frame-done is raised, the outputs are unchanged, and bit 0 of the new frame follows on the next falling edge.
- R9: A sync rise detected on the same falling edge that captures frame bit 255 completes that frame normally and also starts the next frame, so back-to-back frames arrive with no gap.
- R10: Holding sync_i high past the tag slot does not restart the frame. Serial data that arrives after a completed frame and before the next sync rise has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk_i | input | 1 | Link bit clock; all capture is done on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame sync from the link; a rise starts a frame |
| sdata_i | input | 1 | Serial data from the codec |
| codec_ready_o | output | 1 | Codec-ready flag from the last completed frame |
| slot_valid_o | output | 12 | Valid tags; bit k-1 belongs to data slot k |
| slot_data_o | output | 240 | Data slot words; slot k at bits (k-1)*20 +: 20 |
| frame_done_o | output | 1 | One-cycle strobe when a frame's outputs update |

## Verification
Two events can land on the same falling edge: capture of frame bit 255, with its output update and frame-done, and detection of the next sync rise. The bench provokes this by streaming back-to-back frames whose next sync rise is launched together with the final data bit. The expected slot contents of every frame in the chain must then appear once each, in order, with single-cycle strobes. The bench also places a sync rise on the edge that captures frame bit 254, one bit early, where the partial frame must vanish without a strobe. The bench judges every frame from slot values it computes arithmetically itself.

// File: rtl/slink_rx_pkg.sv
package slink_rx_pkg;
  localparam int unsigned DEF_TAG_W     = 16;
  localparam int unsigned DEF_SLOT_W    = 20;
  localparam int unsigned DEF_NUM_SLOTS = 12;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/slink_rx_sync_det.sv
module slink_rx_sync_det (
  input  logic bit_clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic start_o
);
  logic sync_q;

  // reset high so a sync already asserted at reset release is not a rise
  always_ff @(negedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b1;
    else         sync_q <= sync_i;
  end

  assign start_o = sync_i & ~sync_q;
endmodule

// File: rtl/slink_rx_bit_ctr.sv
module slink_rx_bit_ctr #(
  parameter int unsigned TAG_W     = 16,
  parameter int unsigned SLOT_W    = 20,
  parameter int unsigned NUM_SLOTS = 12,
  parameter int unsigned BIT_W     = 5,
  parameter int unsigned SI_W      = 4
) (
  input  logic            bit_clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            run_o,
  output logic [SI_W-1:0] slot_idx_o,
  output logic            slot_end_o,
  output logic            frame_end_o
);
  localparam logic [BIT_W-1:0] TAG_LAST  = BIT_W'(TAG_W - 1);
  localparam logic [BIT_W-1:0] SLOT_LAST = BIT_W'(SLOT_W - 1);
  localparam logic [SI_W-1:0]  LAST_SLOT = SI_W'(NUM_SLOTS);

  logic             run_q;
  logic [SI_W-1:0]  slot_q;
  logic [BIT_W-1:0] bit_q;
  logic [BIT_W-1:0] last_bit;

  assign last_bit    = (slot_q == '0) ? TAG_LAST : SLOT_LAST;
  assign slot_end_o  = run_q && (bit_q == last_bit);
  assign frame_end_o = slot_end_o && (slot_q == LAST_SLOT);
  assign run_o       = run_q;
  assign slot_idx_o  = slot_q;

  always_ff @(negedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      slot_q <= '0;
      bit_q  <= '0;
    end else if (start_i) begin
      // new frame wins; a frame ending on this edge is still reported via frame_end_o
      run_q  <= 1'b1;
      slot_q <= '0;
      bit_q  <= '0;
    end else if (run_q) begin
      if (frame_end_o) begin
        run_q <= 1'b0;
      end else if (slot_end_o) begin
        slot_q <= slot_q + 1'b1;
        bit_q  <= '0;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/slink_rx_shift.sv
module slink_rx_shift #(
  parameter int unsigned W = 20
) (
  input  logic         bit_clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sh_q;

  // word_o includes the bit being captured on this edge
  assign word_o = {sh_q[W-2:0], bit_i};

  always_ff @(negedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (en_i) sh_q <= word_o;
  end
endmodule

// File: rtl/slink_rx_deframer.sv
module slink_rx_deframer
  import slink_rx_pkg::*;
#(
  parameter int unsigned TAG_W     = DEF_TAG_W,
  parameter int unsigned SLOT_W    = DEF_SLOT_W,
  parameter int unsigned NUM_SLOTS = DEF_NUM_SLOTS
) (
  input  logic                        bit_clk_i,
  input  logic                        rst_ni,
  input  logic                        sync_i,
  input  logic                        sdata_i,
  output logic                        codec_ready_o,
  output logic [NUM_SLOTS-1:0]        slot_valid_o,
  output logic [NUM_SLOTS*SLOT_W-1:0] slot_data_o,
  output logic                        frame_done_o
);
  localparam int unsigned MAX_LEN = max_u(TAG_W, SLOT_W);
  localparam int unsigned BIT_W   = $clog2(MAX_LEN);
  localparam int unsigned SI_W    = $clog2(NUM_SLOTS + 1);
  localparam int unsigned HDR_W   = NUM_SLOTS + 1;  // ready + valid tags

  logic               start;
  logic               run;
  logic [SI_W-1:0]    slot_idx;
  logic               slot_end;
  logic               frame_end;
  logic [MAX_LEN-1:0] word;
  logic [HDR_W-1:0]   hdr_q;
  logic               ready_q;
  logic               done_q;

  slink_rx_sync_det i_sync_det (
    .bit_clk_i (bit_clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync_i),
    .start_o   (start)
  );

  slink_rx_bit_ctr #(
    .TAG_W     (TAG_W),
    .SLOT_W    (SLOT_W),
    .NUM_SLOTS (NUM_SLOTS),
    .BIT_W     (BIT_W),
    .SI_W      (SI_W)
  ) i_bit_ctr (
    .bit_clk_i   (bit_clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .run_o       (run),
    .slot_idx_o  (slot_idx),
    .slot_end_o  (slot_end),
    .frame_end_o (frame_end)
  );

  slink_rx_shift #(
    .W (MAX_LEN)
  ) i_shift (
    .bit_clk_i (bit_clk_i),
    .rst_ni    (rst_ni),
    .en_i      (run),
    .bit_i     (sdata_i),
    .word_o    (word)
  );

  // only the ready flag and the per-slot tags are kept from the tag slot
  always_ff @(negedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni)                          hdr_q <= '0;
    else if (slot_end && slot_idx == '0) hdr_q <= word[TAG_W-1 -: HDR_W];
  end

  always_ff @(negedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= frame_end;
      if (frame_end) ready_q <= hdr_q[HDR_W-1];
    end
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic [SLOT_W-1:0] src;
    logic [SLOT_W-1:0] data_q;
    logic              valid_q;

    if (k < NUM_SLOTS - 1) begin : g_stage
      logic [SLOT_W-1:0] stage_q;
      always_ff @(negedge bit_clk_i or negedge rst_ni) begin
        if (!rst_ni)                                    stage_q <= '0;
        else if (slot_end && slot_idx == SI_W'(k + 1)) stage_q <= word[SLOT_W-1:0];
      end
      assign src = stage_q;
    end else begin : g_last
      // final slot goes straight from the shifter on the frame's last edge
      assign src = word[SLOT_W-1:0];
    end

    always_ff @(negedge bit_clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q  <= '0;
        valid_q <= 1'b0;
      end else if (frame_end) begin
        data_q  <= src;
        valid_q <= hdr_q[HDR_W-2-k];
      end
    end

    assign slot_data_o[k*SLOT_W +: SLOT_W] = data_q;
    assign slot_valid_o[k]                 = valid_q;
  end

  assign codec_ready_o = ready_q;
  assign frame_done_o  = done_q;
endmodule

// File: rtl/slink_rx_deframer_chk.sv
module slink_rx_deframer_chk #(
  parameter int unsigned SLOT_W     = 20,
  parameter int unsigned NUM_SLOTS  = 12,
  parameter int unsigned FRAME_BITS = 256
) (
  input logic                        bit_clk_i,
  input logic                        rst_ni,
  input logic                        sync_i,
  input logic                        codec_ready_o,
  input logic [NUM_SLOTS-1:0]        slot_valid_o,
  input logic [NUM_SLOTS*SLOT_W-1:0] slot_data_o,
  input logic                        frame_done_o
);
  localparam int unsigned CW = $clog2(FRAME_BITS) + 1;
  localparam logic [CW-1:0] SAT = '1;

  logic          sync_q;
  logic [CW-1:0] gap_q;  // falling edges since last sync rise, saturating

  always_ff @(negedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b1;
      gap_q  <= SAT;
    end else begin
      sync_q <= sync_i;
      if (sync_i && !sync_q) gap_q <= '0;
      else if (gap_q != SAT) gap_q <= gap_q + 1'b1;
    end
  end

  a_r1_reset_quiet: assert property (@(negedge bit_clk_i)
    !rst_ni |-> (!codec_ready_o && slot_valid_o == '0 && slot_data_o == '0 && !frame_done_o));

  a_r7_done_single: assert property (@(negedge bit_clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  a_r7_data_hold: assert property (@(negedge bit_clk_i) disable iff (!rst_ni)
    !$stable(slot_data_o) |-> frame_done_o);

  a_r5_valid_hold: assert property (@(negedge bit_clk_i) disable iff (!rst_ni)
    !$stable(slot_valid_o) |-> frame_done_o);

  a_r4_ready_hold: assert property (@(negedge bit_clk_i) disable iff (!rst_ni)
    !$stable(codec_ready_o) |-> frame_done_o);

  // done only after exactly FRAME_BITS captures following a sync rise (R8, R9)
  a_r8_done_after_full: assert property (@(negedge bit_clk_i) disable iff (!rst_ni)
    frame_done_o |-> $past(gap_q) == CW'(FRAME_BITS - 1));
endmodule

bind slink_rx_deframer slink_rx_deframer_chk #(
  .SLOT_W     (SLOT_W),
  .NUM_SLOTS  (NUM_SLOTS),
  .FRAME_BITS (TAG_W + NUM_SLOTS * SLOT_W)
) i_chk (
  .bit_clk_i     (bit_clk_i),
  .rst_ni        (rst_ni),
  .sync_i        (sync_i),
  .codec_ready_o (codec_ready_o),
  .slot_valid_o  (slot_valid_o),
  .slot_data_o   (slot_data_o),
  .frame_done_o  (frame_done_o)
);

// File: tb/test_slink_rx_deframer.sv
module test_slink_rx_deframer;
  localparam int NS = 12;
  localparam int SW = 20;
  localparam int FB = 256;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sync = 1'b0;
  logic             sdata = 1'b0;
  logic             ready;
  logic [NS-1:0]    valid;
  logic [NS*SW-1:0] data;
  logic             done;

  int checks = 0;
  int fails  = 0;
  int exp_wr = 0;
  int exp_rd = 0;
  bit finished = 1'b0;
  logic             exp_ready [64];
  logic [NS-1:0]    exp_valid [64];
  logic [NS*SW-1:0] exp_data  [64];

  always #5 clk = ~clk;

  slink_rx_deframer i_slink_rx_deframer (
    .bit_clk_i     (clk),
    .rst_ni        (rst_n),
    .sync_i        (sync),
    .sdata_i       (sdata),
    .codec_ready_o (ready),
    .slot_valid_o  (valid),
    .slot_data_o   (data),
    .frame_done_o  (done)
  );

  function automatic logic [FB-1:0] mk(input int n);
    logic [FB-1:0] f;
    logic [15:0]   tag;
    logic [SW-1:0] w;
    tag = (n == 0) ? 16'hFFFF : (n == 1) ? 16'h0000 : (n == 2) ? 16'hAAAA : 16'(n * 40503 + 4660);
    f[255:240] = tag;
    for (int k = 1; k <= NS; k++) begin
      w = 20'(n * 7919 + k * 104729 + k * k * n * 31);
      if ((n + k) % 5 == 0) w = '0;
      if (n == 0) w = '1;
      if (n == 2) w = k[0] ? 20'hAAAAA : 20'h55555;
      f[239 - 20 * (k - 1) -: 20] = w;
    end
    return f;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push_exp(input logic [FB-1:0] f);
    exp_ready[exp_wr % 64] = f[255];  // R4: frame bit 0
    for (int k = 1; k <= NS; k++) begin
      exp_valid[exp_wr % 64][k - 1] = f[255 - k];  // R5
      exp_data[exp_wr % 64][(k - 1) * SW +: SW] = f[239 - 20 * (k - 1) -: 20];  // R3, R6
    end
    exp_wr++;
  endtask

  // sync rise must already be on the link; bit 0 launches on the next rising edge
  task automatic send_bits(input logic [FB-1:0] f, input int nbits, input bit rise_at_last, input int hold);
    for (int i = 0; i < nbits; i++) begin
      tick();
      sdata = f[255 - i];
      if (i == hold) sync = 1'b0;
      if (rise_at_last && i == nbits - 1) sync = 1'b1;
    end
    if (nbits == FB) push_exp(f);
  endtask

  task automatic idle(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      tick();
      sdata = ((seed + i * 7) % 3) != 0;
      sync = 1'b0;
    end
  endtask

  task automatic rise();
    tick();
    sync = 1'b1;
  endtask

  // output monitor, sampling between falling edges
  logic             prev_done = 1'b0;
  logic             hold_ready = 1'b0;
  logic [NS-1:0]    hold_valid = '0;
  logic [NS*SW-1:0] hold_data = '0;

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        if (done) begin
          checks++;
          if (prev_done) begin
            fails++;
            $display("FAIL R7 frame_done width got %0d cycles exp 1", 2);
          end
          if (exp_rd == exp_wr) begin
            checks++; fails++;
            $display("FAIL R8 unexpected frame_done got 1 exp 0");
          end else begin
            checks += 3;
            if (ready !== exp_ready[exp_rd % 64]) begin
              fails++;
              $display("FAIL R4 codec_ready got %b exp %b", ready, exp_ready[exp_rd % 64]);
            end
            if (valid !== exp_valid[exp_rd % 64]) begin
              fails++;
              $display("FAIL R5 slot_valid got %h exp %h", valid, exp_valid[exp_rd % 64]);
            end
            if (data !== exp_data[exp_rd % 64]) begin
              fails++;
              $display("FAIL R6 slot_data got %h exp %h", data, exp_data[exp_rd % 64]);
            end
            exp_rd++;
          end
        end else begin
          checks++;  // R7/R10: outputs hold without a strobe
          if (ready !== hold_ready || valid !== hold_valid || data !== hold_data) begin
            fails++;
            $display("FAIL R10 outputs changed without frame_done got %h exp %h", data, hold_data);
          end
        end
      end
      prev_done  = done;
      hold_ready = ready;
      hold_valid = valid;
      hold_data  = data;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1: reset state
    checks++;
    if (ready !== 1'b0 || valid !== '0 || data !== '0 || done !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs got %b/%h/%h/%b exp 0", ready, valid, data, done);
    end
    rst_n = 1'b1;
    repeat (2) tick();

    // R2, R3, R9: back-to-back chain, next rise launched with the last bit
    rise();
    for (int f = 0; f < 10; f++) send_bits(mk(f), FB, f < 9, 15);
    // R10: trailing data after a completed frame
    idle(40, 1);

    // R8: abandons after 2, 101 and 255 bits (last one hits bit 254)
    rise();
    send_bits(mk(100), 2, 1'b1, 0);
    send_bits(mk(101), 101, 1'b1, 15);
    send_bits(mk(102), 255, 1'b1, 15);
    send_bits(mk(10), FB, 1'b0, 15);
    idle(5, 2);

    // R10: sync held high deep into the data slots
    rise();
    send_bits(mk(11), FB, 1'b0, 200);
    idle(10, 3);

    // mixed gaps and chains
    for (int f = 12; f < 24; f++) begin
      rise();
      send_bits(mk(f), FB, 1'b0, 15);
      idle(1 + (f % 4) * 3, f);
    end
    idle(4, 9);

    // R9: every complete frame delivered once
    checks++;
    if (exp_rd != exp_wr) begin
      fails++;
      $display("FAIL R9 frames delivered got %0d exp %0d", exp_rd, exp_wr);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule